// File: doc/BRIEF.md
# Balanced Partial-Scan Test Sequencer

This block combines a small sequential circuit with a test controller for it. The circuit has one scan register and a chain of unscanned pipeline registers. A single path runs from the scan register and the primary inputs through an entry cloud, through `DEPTH` unscanned stages, and back through a final cloud into the scan register. Every path between two clouds therefore crosses the same number of registers, and no cloud feeds itself without passing a register. Because of this balance, a combinational test pattern can exercise the whole sequential circuit.

A tester sets the primary-input half of a pattern on `pi`, raises `start` and shifts the pseudo-input half in serially. The controller then freezes the scan register while it clocks only the unscanned stages `DEPTH` times. It captures the response into the scan register with one normal-mode clock. The response is then shifted out while the next pattern is shifted in. After the last pattern has been unloaded, the controller raises `done` for one cycle and returns to idle. In idle the circuit runs in normal mode.

States: IDLE (normal operation), LOAD (first scan-in), HOLD (unscanned stages pulsed, scan path frozen), CAPT (one normal-mode capture), XFER (unload of one response overlapped with load of the next pattern) and FIN (completion cycle). Transitions: IDLE to LOAD on `start`; LOAD to HOLD after `SCAN_W` shifts; HOLD to CAPT after `DEPTH` pulses; CAPT to XFER always; XFER to HOLD after `SCAN_W` shifts when patterns remain, otherwise XFER to FIN; FIN to IDLE always.

Top module: `bpscan_top`

## Requirements
- R1: While `rst_n` is low, and on its release, all registers hold zero, the state is IDLE, `scan_shift`, `done` and `scan_out` are 0, and `po` equals g(0). The function g(x) rotates x left by one bit, ({x[W-2:0], x[W-1]}), then XORs the result with a mask that has a 1 in every even bit position (8'h55 for W=8).
- R2: In IDLE the circuit runs in normal mode on every clock. Unscanned stage 0 loads (scan register + `pi`) mod 2^W. Stage k>0 loads g(stage k-1). The scan register loads g(last stage). `po` always equals g(last stage), and `scan_out` is the scan register's most significant bit.
- R3: `start` seen in IDLE moves the controller to LOAD on the next clock. While `scan_shift` is 1, each clock moves the scan register to {q[W-2:0], `scan_in`}. LOAD lasts exactly `SCAN_W` cycles, so the first bit shifted in ends up in the most significant bit.
- R4: After each group of `SCAN_W` shift cycles that loads a pattern, `scan_shift` is 0 for exactly `DEPTH`+1 cycles. The first `DEPTH` of these advance only the unscanned stages while the scan register holds. The last one is the capture cycle, where only the scan register loads.
- R5: For a pattern with scan part s and input part p (held during HOLD), the captured response is g applied `DEPTH` times to (s+p) mod 2^W. It leaves on `scan_out` most significant bit first, one bit per cycle of the following XFER.
- R6: From the capture until the next HOLD, `po` holds that same response.
- R7: One run processes `npat_m1`+1 patterns. `npat_m1` is sampled only with `start`. Each XFER group loads the next pattern while it unloads the previous response.
- R8: After the final XFER group, `done` is 1 for exactly one cycle (with `scan_shift` 0), then the controller is in IDLE.
- R9: `start` has no effect outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test run (sampled in IDLE) |
| npat_m1 | input | NPAT_W | Number of patterns in the run minus one |
| pi | input | SCAN_W | Primary inputs of the circuit |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Serial scan data out (scan register MSB) |
| po | output | SCAN_W | Primary outputs of the circuit |
| scan_shift | output | 1 | High in cycles where the scan path shifts |
| done | output | 1 | One-cycle completion flag |

## Verification
A hold counter off by one pulse shows up in two ways. The gap of non-shift cycles between scan groups has the wrong length at once. The first response bit on `scan_out` is also wrong, because the last stage would hold g applied too few or too many times. A scan register that fails to hold during HOLD corrupts stage 0 on the second pulse, and this shows in the next unload and on `po` from the capture cycle on. A wrong pattern count or a lost pattern register shows up as a missing or early `done` and as wrong bits within one XFER group.

// File: rtl/bpscan_pkg.sv
package bpscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HOLD,
        ST_CAPT,
        ST_XFER,
        ST_FIN
    } state_t;

    typedef enum logic [1:0] {
        SEL_SHIFT,
        SEL_HOLD,
        SEL_FUNC
    } sel_t;

endpackage

// File: rtl/bpscan_ctrl.sv
module bpscan_ctrl
    import bpscan_pkg::*;
#(
    parameter int SCAN_W = 8,
    parameter int DEPTH  = 2,
    parameter int NPAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPAT_W-1:0] npat_m1,
    output sel_t              scan_sel,
    output logic              u_en,
    output logic              scan_shift,
    output logic              done
);
    localparam int MAXC  = (SCAN_W > DEPTH) ? SCAN_W : DEPTH;
    localparam int CNT_W = $clog2(MAXC) + 1;
    localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(SCAN_W - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(DEPTH - 1);

    state_t             st, st_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [NPAT_W-1:0]  left, left_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            left <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            left <= left_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        left_n = left;
        unique case (st)
            ST_IDLE: if (start) begin
                st_n   = ST_LOAD;
                cnt_n  = '0;
                left_n = npat_m1;
            end
            ST_LOAD: if (cnt == SHIFT_LAST) begin
                st_n  = ST_HOLD;
                cnt_n = '0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
            ST_HOLD: if (cnt == HOLD_LAST) begin
                st_n  = ST_CAPT;
                cnt_n = '0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
            ST_CAPT: begin
                st_n  = ST_XFER;
                cnt_n = '0;
            end
            ST_XFER: if (cnt == SHIFT_LAST) begin
                cnt_n = '0;
                if (left == '0) begin
                    st_n = ST_FIN;
                end else begin
                    st_n   = ST_HOLD;
                    left_n = left - 1'b1;
                end
            end else begin
                cnt_n = cnt + 1'b1;
            end
            ST_FIN:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scan_sel   = SEL_HOLD;
        u_en       = 1'b0;
        scan_shift = 1'b0;
        done       = 1'b0;
        unique case (st)
            ST_IDLE: begin
                scan_sel = SEL_FUNC;
                u_en     = 1'b1;
            end
            ST_LOAD, ST_XFER: begin
                scan_sel   = SEL_SHIFT;
                scan_shift = 1'b1;
            end
            ST_HOLD: u_en     = 1'b1;
            ST_CAPT: scan_sel = SEL_FUNC;
            ST_FIN:  done     = 1'b1;
            default: scan_sel = SEL_HOLD;
        endcase
    end
endmodule

// File: rtl/bpscan_scanreg.sv
module bpscan_scanreg
    import bpscan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sel_t         sel,
    input  logic         scan_in,
    input  logic [W-1:0] func_d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (sel)
                SEL_SHIFT: q <= {q[W-2:0], scan_in};
                SEL_FUNC:  q <= func_d;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/bpscan_stage.sv
module bpscan_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/bpscan_top.sv
module bpscan_top
    import bpscan_pkg::*;
#(
    parameter int SCAN_W = 8,
    parameter int DEPTH  = 2,
    parameter int NPAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPAT_W-1:0] npat_m1,
    input  logic [SCAN_W-1:0] pi,
    input  logic              scan_in,
    output logic              scan_out,
    output logic [SCAN_W-1:0] po,
    output logic              scan_shift,
    output logic              done
);
    function automatic logic [SCAN_W-1:0] mix_mask();
        logic [SCAN_W-1:0] m;
        for (int i = 0; i < SCAN_W; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction

    // cloud between two registers
    function automatic logic [SCAN_W-1:0] cloud_mid(input logic [SCAN_W-1:0] x);
        return {x[SCAN_W-2:0], x[SCAN_W-1]} ^ mix_mask();
    endfunction

    sel_t              scan_sel;
    logic              u_en;
    logic [SCAN_W-1:0] scan_q;
    logic [SCAN_W-1:0] stage_d [DEPTH];
    logic [SCAN_W-1:0] stage_q [DEPTH];
    logic [SCAN_W-1:0] cap_d;

    bpscan_ctrl #(.SCAN_W(SCAN_W), .DEPTH(DEPTH), .NPAT_W(NPAT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .npat_m1(npat_m1),
        .scan_sel(scan_sel), .u_en(u_en), .scan_shift(scan_shift), .done(done)
    );

    bpscan_scanreg #(.W(SCAN_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .sel(scan_sel), .scan_in(scan_in),
        .func_d(cap_d), .q(scan_q)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_entry
            assign stage_d[k] = scan_q + pi;
        end else begin : g_mid
            assign stage_d[k] = cloud_mid(stage_q[k-1]);
        end
        bpscan_stage #(.W(SCAN_W)) u_stage (
            .clk(clk), .rst_n(rst_n), .en(u_en), .d(stage_d[k]), .q(stage_q[k])
        );
    end

    assign cap_d    = cloud_mid(stage_q[DEPTH-1]);
    assign po       = cap_d;
    assign scan_out = scan_q[SCAN_W-1];
endmodule

// File: rtl/bpscan_chk.sv
module bpscan_chk
    import bpscan_pkg::*;
#(
    parameter int SCAN_W = 8,
    parameter int DEPTH  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input sel_t              scan_sel,
    input logic              u_en,
    input logic              scan_in,
    input logic [SCAN_W-1:0] scan_q,
    input logic [SCAN_W-1:0] po,
    input logic              scan_shift,
    input logic              done
);
    localparam int HC_W = $clog2(DEPTH + 2) + 1;
    localparam logic [HC_W-1:0] HC_MAX = HC_W'(DEPTH + 1);

    logic [HC_W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   hold_cnt <= '0;
        else if (scan_sel == SEL_SHIFT)               hold_cnt <= '0;
        else if (scan_sel == SEL_HOLD && u_en && hold_cnt != HC_MAX)
                                                      hold_cnt <= hold_cnt + 1'b1;
    end

    p_shift_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_sel == SEL_SHIFT) |=> (scan_q == {$past(scan_q[SCAN_W-2:0]), $past(scan_in)}));

    p_hold_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_sel == SEL_FUNC && !u_en) |-> (hold_cnt == HC_W'(DEPTH)));

    p_scan_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_sel == SEL_HOLD) |=> $stable(scan_q));

    p_po_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!u_en) |=> $stable(po));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(scan_shift));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && scan_shift));
endmodule

bind bpscan_top bpscan_chk #(.SCAN_W(SCAN_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_sel(scan_sel), .u_en(u_en),
    .scan_in(scan_in), .scan_q(scan_q), .po(po),
    .scan_shift(scan_shift), .done(done)
);

// File: tb/bpscan_top_bench.sv
`timescale 1ns/1ps
module bpscan_top_bench;
    localparam int W  = 8;
    localparam int D  = 2;
    localparam int PW = 4;
    localparam int NV = 6;

    // {pi, scan pattern}
    localparam logic [2*W-1:0] VEC [NV] = '{
        16'h00_00, 16'hFF_01, 16'h3C_A5, 16'h80_80, 16'h12_ED, 16'h7F_FE
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] npat_m1 = '0;
    logic [W-1:0]  pi = '0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [W-1:0]  po;
    logic          scan_shift;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bpscan_top #(.SCAN_W(W), .DEPTH(D), .NPAT_W(PW)) u_bpscan_top (
        .clk(clk), .rst_n(rst_n), .start(start), .npat_m1(npat_m1), .pi(pi),
        .scan_in(scan_in), .scan_out(scan_out), .po(po),
        .scan_shift(scan_shift), .done(done)
    );

    function automatic logic [W-1:0] fmask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction

    function automatic logic [W-1:0] g(input logic [W-1:0] x);
        return {x[W-2:0], x[W-1]} ^ fmask();
    endfunction

    function automatic logic [W-1:0] resp(input logic [W-1:0] s, input logic [W-1:0] p);
        logic [W-1:0] v = s + p;
        for (int i = 0; i < D; i++) v = g(v);
        return v;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // called at a negedge in IDLE; returns at the first IDLE negedge after FIN
    task automatic run(input int first, input int n, input logic [W-1:0] fill, input bit poke);
        logic [W-1:0] rsp [NV];
        for (int p = 0; p < n; p++)
            rsp[p] = resp(VEC[first+p][W-1:0], VEC[first+p][2*W-1:W]);
        pi      = VEC[first][2*W-1:W];
        npat_m1 = PW'(n - 1);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        npat_m1 = ~npat_m1;   // R7: must be ignored after start
        for (int p = 0; p <= n; p++) begin
            for (int k = 0; k < W; k++) begin
                chk("R3 scan_shift in shift group", W'(scan_shift), W'(1));
                if (p > 0) begin
                    chk("R5 response bit on scan_out", W'(scan_out), W'(rsp[p-1][W-1-k]));
                    if (k == 0) chk("R6 po holds response", po, rsp[p-1]);
                end
                if (k == 0 && p < n) pi = VEC[first+p][2*W-1:W];
                scan_in = (p < n) ? VEC[first+p][W-1-k] : fill[W-1-k];
                @(negedge clk);
            end
            if (p < n) begin
                for (int q = 0; q <= D; q++) begin
                    chk("R4 hold and capture gap", W'(scan_shift), W'(0));
                    chk("R7 no early done", W'(done), W'(0));
                    if (poke && q == 0) start = 1'b1;   // R9
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        end
        chk("R8 done after last unload", W'(done), W'(1));
        chk("R8 no shift with done", W'(scan_shift), W'(0));
        @(negedge clk);
        chk("R8 done one cycle", W'(done), W'(0));
        chk("R8 idle after done", W'(scan_shift), W'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ms;
        logic [W-1:0] mu [D];
        logic [W-1:0] nu [D];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 po at reset", po, g('0));
        chk("R1 scan_shift at reset", W'(scan_shift), W'(0));
        chk("R1 done at reset", W'(done), W'(0));
        chk("R1 scan_out at reset", W'(scan_out), W'(0));
        @(negedge clk);

        // table walk: all vectors in one run
        run(0, NV, 8'hC3, 1'b0);

        // R2: normal mode in idle, modelled from known state
        ms    = 8'hC3;
        mu[0] = VEC[NV-1][W-1:0] + VEC[NV-1][2*W-1:W];
        for (int k = 1; k < D; k++) mu[k] = g(mu[k-1]);
        for (int c = 0; c < 6; c++) begin
            chk("R2 po in normal mode", po, g(mu[D-1]));
            chk("R2 scan_out in normal mode", W'(scan_out), W'(ms[W-1]));
            pi = W'(c * 37 + 5);
            nu[0] = ms + pi;
            for (int k = 1; k < D; k++) nu[k] = g(mu[k-1]);
            ms = g(mu[D-1]);
            for (int k = 0; k < D; k++) mu[k] = nu[k];
            @(negedge clk);
        end

        // single pattern, start raised during hold (R9)
        run(2, 1, 8'h00, 1'b1);
        // partial table, different fill
        run(1, 4, 8'h5A, 1'b1);
        // last two vectors alone
        run(4, 2, 8'hFF, 1'b0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule